// File: doc/BRIEF.md
# Shadow Register Commit Controller

This block holds the configuration registers of a display compositor in two copies. Software writes and reads a shadow copy through a simple word-addressed 32-bit register port. The compositor logic sees only the active copy. At a vertical blanking strobe the whole shadow set is copied into the active set in one clock edge, so a frame never shows a half-written configuration.

A control word at word 0 governs the copy. Setting its request bit arms a single copy at the next blanking strobe. The hardware clears the request bit at that copy, and software polls it until it reads 0 before starting the next batch of updates. Software usually sets the hold bit in the same write, which turns off the automatic copy. With the hold bit clear, every blanking strobe copies the shadow set whether or not a request is armed. After reset the shadow words may be treated as unknown, and software clears the whole window to zero word by word before first use. A build parameter chooses whether the shadow flops have a reset at all.

Top module: `shadow_commit_ctrl`

## Requirements
- R1: After reset the active outputs are all zero, the read-valid output is low, the control word reads 0 (request bit 0 clear, hold bit 1 clear), and with the default build every shadow word reads 0.
- R2: The address is a byte address and the word index is address bits [ADDR_W-1:2]. A write to word k, with 1 <= k <= N_REGS, stores the data in shadow register k-1. A read asserts rd_valid for exactly one cycle on the edge that follows rd_en, and rd_data then holds the value the register had before that edge.
- R3: A write to word 0 with data bit 0 set arms a load request. The request bit then reads back as 1 until the copy that consumes it.
- R4: On a blanking strobe with a request armed, all shadow registers are copied into the active set on that clock edge, and the request bit is cleared on the same edge.
- R5: On a blanking strobe with the hold bit (data bit 1 of word 0) set and no request armed, the active outputs stay unchanged.
- R6: With the hold bit clear, every blanking strobe copies the shadow set into the active set, with no request needed.
- R7: The active outputs change only on an edge where the blanking strobe is high.
- R8: If a shadow write and a copy fall on the same edge, the active set receives the value from before the write, and the written value stays in the shadow set for the next copy.
- R9: A control write on a blanking edge does not affect that edge's copy decision. A request written then stays armed for the following strobe, and a new hold value takes effect from the next edge.
- R10: The two low address bits are ignored. Writes to words above N_REGS change nothing, and reads of those words return 0.
- R11: A control write with data bit 0 clear does not cancel an armed request. Every control write loads the hold bit from data bit 1. A control read returns the request bit in bit 0 and the hold bit in bit 1, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | DATA_W | Read data |
| vblank | input | 1 | Vertical blanking strobe, one cycle per frame |
| act_regs | output | N_REGS*DATA_W | Active register set, register i in bits [i*DATA_W +: DATA_W] |

## Verification
The checker verifies on every cycle that the active outputs stay frozen away from blanking strobes and when held, and that each copy reproduces the shadow set from before the edge. It also verifies the full life of the request bit: it is set by a control write, it survives idle cycles and cancel attempts, and it is cleared only by the copy. On every read it checks the control-word layout and the zero returned for unmapped words. Only the bench scenarios can show the same-edge collisions between writes and copies, that a window of words cleared to zero reaches the outputs after a commit, and that the per-register data paths line up with their addresses. The bench covers these with directed sequences and a long random run against a reference model.

// File: rtl/shc_pkg.sv
package shc_pkg;
   localparam int CTRL_REQ_BIT  = 0;
   localparam int CTRL_HOLD_BIT = 1;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_CTRL   = 2'd1,
      SEL_SHADOW = 2'd2
   } sel_e;
endpackage

// File: rtl/shc_addr_dec.sv
module shc_addr_dec
   import shc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int N_REGS = 8,
   parameter int IDX_W  = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel,
   output logic [IDX_W-1:0]  idx
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   wire               unused_lsb = ^addr[1:0];

   assign word = addr[ADDR_W-1:2];

   always_comb begin
      sel = SEL_NONE;
      idx = '0;
      if (word == '0) begin
         sel = SEL_CTRL;
      end else if (word <= WORD_W'(N_REGS)) begin
         sel = SEL_SHADOW;
         idx = IDX_W'(word - WORD_W'(1));
      end
   end
endmodule

// File: rtl/shc_load_seq.sv
module shc_load_seq #(
   parameter bit HOLD_AT_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vblank,
   input  logic ctrl_we,
   input  logic ctrl_req,
   input  logic ctrl_hold,
   output logic copy,
   output logic pend_q,
   output logic hold_q
);
   // decision uses register state from before the edge
   assign copy = vblank & (pend_q | ~hold_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (ctrl_we && ctrl_req) begin
         pend_q <= 1'b1;
      end else if (copy) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= HOLD_AT_RESET;
      end else if (ctrl_we) begin
         hold_q <= ctrl_hold;
      end
   end
endmodule

// File: rtl/shc_bank.sv
module shc_bank #(
   parameter int N_REGS       = 8,
   parameter int DATA_W       = 32,
   parameter int IDX_W        = 3,
   parameter bit RESET_SHADOW = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     copy,
   output logic [N_REGS*DATA_W-1:0] shadow_flat,
   output logic [N_REGS*DATA_W-1:0] active_flat
);
   for (genvar g = 0; g < N_REGS; g++) begin : g_reg
      logic              hit;
      logic [DATA_W-1:0] sh_q;
      logic [DATA_W-1:0] ac_q;

      assign hit = wr_en && (wr_idx == IDX_W'(g));

      if (RESET_SHADOW) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else if (hit) begin
               sh_q <= wr_data;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) begin
               sh_q <= wr_data;
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ac_q <= '0;
         end else if (copy) begin
            ac_q <= sh_q;
         end
      end

      assign shadow_flat[g*DATA_W +: DATA_W] = sh_q;
      assign active_flat[g*DATA_W +: DATA_W] = ac_q;
   end
endmodule

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl
   import shc_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32,
   parameter int N_REGS        = 8,
   parameter bit RESET_SHADOW  = 1'b1,
   parameter bit HOLD_AT_RESET = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic                     rd_valid,
   output logic [DATA_W-1:0]        rd_data,
   input  logic                     vblank,
   output logic [N_REGS*DATA_W-1:0] act_regs
);
   localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must hold the two control bits");
   end
   if (N_REGS < 1) begin : g_bad_count
      $error("N_REGS must be at least 1");
   end
   if (ADDR_W < 3 || (N_REGS + 1) > (1 << (ADDR_W - 2))) begin : g_bad_map
      $error("ADDR_W too small for control word plus N_REGS shadow words");
   end

   sel_e              wsel;
   sel_e              rsel;
   logic [IDX_W-1:0]  widx;
   logic [IDX_W-1:0]  ridx;
   logic              copy;
   logic              pend_q;
   logic              hold_q;
   logic [N_REGS*DATA_W-1:0] shadow_flat;
   logic [DATA_W-1:0] rd_next;
   logic [DATA_W-1:0] ctrl_view;

   shc_addr_dec #(.ADDR_W(ADDR_W), .N_REGS(N_REGS), .IDX_W(IDX_W)) u_wdec (
      .addr (wr_addr),
      .sel  (wsel),
      .idx  (widx)
   );

   shc_addr_dec #(.ADDR_W(ADDR_W), .N_REGS(N_REGS), .IDX_W(IDX_W)) u_rdec (
      .addr (rd_addr),
      .sel  (rsel),
      .idx  (ridx)
   );

   shc_load_seq #(.HOLD_AT_RESET(HOLD_AT_RESET)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .vblank    (vblank),
      .ctrl_we   (wr_en && (wsel == SEL_CTRL)),
      .ctrl_req  (wr_data[CTRL_REQ_BIT]),
      .ctrl_hold (wr_data[CTRL_HOLD_BIT]),
      .copy      (copy),
      .pend_q    (pend_q),
      .hold_q    (hold_q)
   );

   shc_bank #(
      .N_REGS       (N_REGS),
      .DATA_W       (DATA_W),
      .IDX_W        (IDX_W),
      .RESET_SHADOW (RESET_SHADOW)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en && (wsel == SEL_SHADOW)),
      .wr_idx      (widx),
      .wr_data     (wr_data),
      .copy        (copy),
      .shadow_flat (shadow_flat),
      .active_flat (act_regs)
   );

   always_comb begin
      ctrl_view                = '0;
      ctrl_view[CTRL_REQ_BIT]  = pend_q;
      ctrl_view[CTRL_HOLD_BIT] = hold_q;
   end

   always_comb begin
      unique case (rsel)
         SEL_CTRL:   rd_next = ctrl_view;
         SEL_SHADOW: rd_next = shadow_flat[ridx*DATA_W +: DATA_W];
         default:    rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data <= rd_next;
         end
      end
   end
endmodule

// File: rtl/shc_commit_chk.sv
module shc_commit_chk
   import shc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int N_REGS = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     vblank,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic [DATA_W-1:0]        wr_data,
   input logic                     rd_en,
   input logic [ADDR_W-1:0]        rd_addr,
   input logic                     rd_valid,
   input logic [DATA_W-1:0]        rd_data,
   input logic [N_REGS*DATA_W-1:0] act_regs,
   input logic [N_REGS*DATA_W-1:0] shadow_flat,
   input logic                     pend_q,
   input logic                     hold_q
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] wr_word;
   logic [WORD_W-1:0] rd_word;
   logic              req_wr;
   wire               unused_bits = ^{wr_addr[1:0], rd_addr[1:0], wr_data};

   assign wr_word = wr_addr[ADDR_W-1:2];
   assign rd_word = rd_addr[ADDR_W-1:2];
   assign req_wr  = wr_en && (wr_word == '0) && wr_data[CTRL_REQ_BIT];

   AST_ACT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !vblank |=> $stable(act_regs)); // R7

   AST_HOLD_NO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      vblank && hold_q && !pend_q |=> $stable(act_regs)); // R5

   AST_AUTO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      vblank && !hold_q |=> act_regs == $past(shadow_flat)); // R6

   AST_REQ_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      vblank && pend_q |=> act_regs == $past(shadow_flat)); // R4

   AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      vblank && pend_q && !req_wr |=> !pend_q); // R4

   AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      req_wr |=> pend_q); // R3

   AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !vblank |=> pend_q); // R3

   AST_RD_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R2

   AST_RD_VALID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid); // R2

   AST_CTRL_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && (rd_word == '0) |=>
         (rd_data[CTRL_REQ_BIT] == $past(pend_q)) &&
         (rd_data[CTRL_HOLD_BIT] == $past(hold_q)) &&
         (rd_data[DATA_W-1:2] == '0)); // R11

   AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && (rd_word > WORD_W'(N_REGS)) |=> rd_data == '0); // R10
endmodule

bind shadow_commit_ctrl shc_commit_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .N_REGS (N_REGS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .vblank      (vblank),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .rd_en       (rd_en),
   .rd_addr     (rd_addr),
   .rd_valid    (rd_valid),
   .rd_data     (rd_data),
   .act_regs    (act_regs),
   .shadow_flat (shadow_flat),
   .pend_q      (pend_q),
   .hold_q      (hold_q)
);

// File: tb/shadow_commit_ctrl_bench.sv
`timescale 1ns/1ps
module shadow_commit_ctrl_bench;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int NR = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [DW-1:0]     wr_data = '0;
   logic              rd_en = 1'b0;
   logic [AW-1:0]     rd_addr = '0;
   logic              rd_valid;
   logic [DW-1:0]     rd_data;
   logic              vblank = 1'b0;
   logic [NR*DW-1:0]  act_regs;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [DW-1:0] m_sh  [NR];
   logic [DW-1:0] m_act [NR];
   bit            m_pend;
   bit            m_hold;

   always #2 clk = ~clk;

   shadow_commit_ctrl u_shadow_commit_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .vblank   (vblank),
      .act_regs (act_regs)
   );

   function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
      int w = int'(a[AW-1:2]);
      if (w == 0) return {30'd0, m_hold, m_pend};
      if (w <= NR) return m_sh[w-1];
      return '0;
   endfunction

   function automatic logic [NR*DW-1:0] model_act();
      logic [NR*DW-1:0] v;
      for (int i = 0; i < NR; i++) v[i*DW +: DW] = m_act[i];
      return v;
   endfunction

   task automatic check(input string req, input logic [NR*DW-1:0] got,
                        input logic [NR*DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   // one clock: inputs driven at negedge, model stepped at posedge,
   // outputs compared at the following negedge
   task automatic cyc(input string req, input bit we, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input bit re,
                      input logic [AW-1:0] ra, input bit vb);
      logic [DW-1:0] exp_rd;
      bit            cp;
      int            w;
      wr_en = we; wr_addr = wa; wr_data = wd;
      rd_en = re; rd_addr = ra; vblank = vb;
      @(posedge clk);
      exp_rd = model_read(ra);
      cp = vb && (m_pend || !m_hold);
      if (cp) begin
         for (int i = 0; i < NR; i++) m_act[i] = m_sh[i];
         m_pend = 1'b0;
      end
      if (we) begin
         w = int'(wa[AW-1:2]);
         if (w == 0) begin
            m_hold = wd[1];
            if (wd[0]) m_pend = 1'b1;
         end else if (w <= NR) begin
            m_sh[w-1] = wd;
         end
      end
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; vblank = 1'b0;
      check({req, " act"}, act_regs, model_act());
      check({req, " rvalid"}, {{(NR*DW-1){1'b0}}, rd_valid},
            {{(NR*DW-1){1'b0}}, re});
      if (re) check({req, " rdata"}, {{(NR*DW-DW){1'b0}}, rd_data},
                    {{(NR*DW-DW){1'b0}}, exp_rd});
   endtask

   function automatic logic [AW-1:0] sh_addr(input int k);
      return AW'((k + 1) * 4);
   endfunction

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1d5e_a7c3));
      for (int i = 0; i < NR; i++) begin m_sh[i] = '0; m_act[i] = '0; end
      m_pend = 1'b0; m_hold = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 act", act_regs, '0);
      check("R1 rvalid", {{(NR*DW-1){1'b0}}, rd_valid}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      cyc("R1 ctrl", 0, 0, 0, 1, 8'h00, 0);
      for (int k = 0; k < NR; k++) cyc("R1 shadow", 0, 0, 0, 1, sh_addr(k), 0);

      // R11 hold on
      cyc("R11 hold", 1, 8'h00, 32'h2, 0, 0, 0);
      cyc("R11 view", 0, 0, 0, 1, 8'h00, 0);
      // R2 window clear and fill
      for (int k = 0; k < NR; k++) cyc("R2 clear", 1, sh_addr(k), 32'h0, 0, 0, 0);
      for (int k = 0; k < NR; k++)
         cyc("R2 fill", 1, sh_addr(k), 32'hA500_0000 + 32'(k * 17), 1, sh_addr(k), 0);
      for (int k = 0; k < NR; k++) cyc("R2 read", 0, 0, 0, 1, sh_addr(k), 0);
      // R5 held strobe without request
      cyc("R5 held", 0, 0, 0, 0, 0, 1);
      // R3 arm request and poll
      cyc("R3 arm", 1, 8'h00, 32'h3, 0, 0, 0);
      cyc("R3 poll", 0, 0, 0, 1, 8'h00, 0);
      cyc("R7 idle", 0, 0, 0, 1, 8'h00, 0);
      // R11 cancel attempt keeps request
      cyc("R11 nocancel", 1, 8'h00, 32'h2, 1, 8'h00, 0);
      cyc("R11 still", 0, 0, 0, 1, 8'h00, 0);
      // R4 commit
      cyc("R4 commit", 0, 0, 0, 1, 8'h00, 1);
      cyc("R4 cleared", 0, 0, 0, 1, 8'h00, 0);
      // R8 write collides with copy
      cyc("R8 arm", 1, 8'h00, 32'h3, 0, 0, 0);
      cyc("R8 collide", 1, sh_addr(2), 32'hDEAD_BEEF, 0, 0, 1);
      cyc("R8 shadow", 0, 0, 0, 1, sh_addr(2), 0);
      cyc("R8 arm2", 1, 8'h00, 32'h3, 0, 0, 0);
      cyc("R8 later", 0, 0, 0, 0, 0, 1);
      // R9 request written on strobe edge
      cyc("R9 edge", 1, 8'h00, 32'h3, 1, 8'h00, 1);
      cyc("R9 pending", 0, 0, 0, 1, 8'h00, 0);
      cyc("R9 next", 0, 0, 0, 1, 8'h00, 1);
      // R10 address handling
      cyc("R10 lowbits", 1, sh_addr(4) | 8'h3, 32'h1234_5678, 1, sh_addr(4) | 8'h2, 0);
      cyc("R10 lowread", 0, 0, 0, 1, sh_addr(4) | 8'h1, 0);
      cyc("R10 miss wr", 1, 8'hFC, 32'hFFFF_FFFF, 1, 8'hFC, 0);
      cyc("R10 miss rd", 0, 0, 0, 1, AW'((NR + 1) * 4), 0);
      // R6 autoload
      cyc("R6 autoon", 1, 8'h00, 32'h0, 0, 0, 0);
      cyc("R6 fill", 1, sh_addr(0), 32'h0BAD_F00D, 0, 0, 0);
      cyc("R6 copy", 0, 0, 0, 0, 0, 1);
      cyc("R6 fill2", 1, sh_addr(7), 32'h7777_0007, 0, 0, 0);
      cyc("R6 copy2", 0, 0, 0, 1, 8'h00, 1);

      // random run against the model, all requirements R2..R11
      for (int n = 0; n < 4000; n++) begin
         bit            we = ($urandom_range(0, 2) != 0);
         bit            re = ($urandom_range(0, 1) != 0);
         bit            vb = ($urandom_range(0, 11) == 0);
         int            pick = $urandom_range(0, 9);
         logic [AW-1:0] wa;
         logic [DW-1:0] wd = $urandom();
         if (pick == 0) begin
            wa = 8'h00;
            wd = {30'd0, ($urandom_range(0, 4) != 0), wd[0]};
         end else if (pick == 1) begin
            wa = AW'($urandom_range(NR + 1, 63) * 4);
         end else begin
            wa = sh_addr($urandom_range(0, NR - 1));
         end
         wa[1:0] = 2'($urandom_range(0, 3));
         cyc("R2-model", we, wa, wd, re, AW'($urandom_range(0, 255)), vb);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule